// File: doc/BRIEF.md
# SDRAM Precharge Timing Scheduler

This block sits on the controller side of a four-bank SDRAM. It takes three request streams, each with a valid/ready handshake: bank activations, column accesses and precharges. A column access is a read or a write to one bank. It carries a burst length and a flag that asks the device to close the bank by itself once the access is over. A precharge request names one bank or asks for all of them. The block chooses at most one request per clock and drives it onto a registered command bus: the row strobe, the column strobe, the write enable, a two-bit bank address and address bit 10. It also keeps a record of which banks are open.

The block stalls precharges until they are legal. After a read, a bank may be closed while its last beats are still on the data bus. The read may be closed CAS latency minus one clocks before its last data beat, so the tail of the data overlaps the precharge. After a write, the bank must wait a write-recovery gap of `TWR` clocks counted from the last data beat in. An access flagged for auto-precharge closes its bank at that same earliest point, and no command appears on the bus for it. CAS latency is a run-time input that may be 2 or 3.

Top module: `sdram_pre_sched`

## Requirements
- R1: Command codes on {ras_n, cas_n, we_n} are: precharge 010, read 101, write 100, activate 011, and no-op 111 in every cycle with no command. Each accepted request appears on the bus in the cycle after the clock edge that accepted it.
- R2: On a single-bank precharge, A10 is driven low and the bank address carries the bank number (0 to 3). On a precharge of all banks, A10 is driven high and the bank address is 0.
- R3: A read or write drives A10 with its auto-precharge flag. A flagged access later closes its bank in the open-bank record, with no precharge command on the bus.
- R4: Take a read issued in command cycle c with burst length BL and CAS latency CL (a value of 2 selects 2; any other value selects 3). Its last data beat falls in cycle c+CL+BL-1. A precharge that covers this bank is issued no earlier than CL-1 cycles before that beat, which is cycle c+BL. If it was requested earlier, it is issued exactly then.
- R5: Take a write issued in cycle c with burst length BL. Its last data beat is in cycle c+BL-1. A precharge that covers this bank is issued no earlier than cycle c+BL-1+TWR. If it was requested earlier, it is issued exactly then.
- R6: An auto-precharge read clears its open bit from cycle c+BL. An auto-precharge write clears its open bit from cycle c+BL-1+TWR.
- R7: A precharge of all banks waits until every bank meets its R4 or R5 limit. After it is issued, all four open bits are 0.
- R8: An activate sets the open bit of its bank, and a single-bank precharge clears it. Both take effect from the cycle in which the command is on the bus. All bits are 0 after reset.
- R9: At most one command goes out per cycle. A legal precharge wins over an access, and an access wins over an activate. A stalled precharge keeps pre_ready low and is issued once it becomes legal.
- R10: An access is accepted only to an open bank with no auto-precharge pending. An activate is accepted only to a closed bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cas_lat | input | 2 | CAS latency, 2 or 3 |
| pre_valid | input | 1 | Precharge request valid |
| pre_ready | output | 1 | Precharge accepted this cycle when valid |
| pre_all | input | 1 | Precharge all banks |
| pre_bank | input | 2 | Bank of a single-bank precharge |
| acc_valid | input | 1 | Column access request valid |
| acc_ready | output | 1 | Access accepted this cycle when valid |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_bank | input | 2 | Access bank |
| acc_burst | input | BL_W | Burst length in beats, 1 to MAX_BL |
| acc_auto | input | 1 | Close the bank automatically after the access |
| act_valid | input | 1 | Activate request valid |
| act_ready | output | 1 | Activate accepted this cycle when valid |
| act_bank | input | 2 | Bank to activate |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | 2 | Bank address |
| cmd_a10 | output | 1 | Address bit 10 |
| bank_open | output | 4 | Open-bank record, one bit per bank |

## Verification
Two events can land on the same clock edge. One is an auto-precharge that closes a bank internally. The other is an explicit precharge of a different bank that becomes legal at that edge. The bench provokes this by issuing a write to bank 2, then an auto-precharge read to bank 1 one cycle later, with burst lengths chosen so that both limits expire together. It then requests a bank-2 precharge early. The scoreboard expects the bank-2 precharge at exactly the computed cycle, and it expects both open bits to fall together in the same cycle. A second overlap sets a precharge request against a column access in the same cycle, and checks that only the precharge is taken.

// File: rtl/psched_pkg.sv
package psched_pkg;
    localparam int unsigned NBANK = 4;
    localparam int unsigned BA_W  = 2;

    typedef enum logic [2:0] {
        CMD_NOP = 3'b111,
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_WR  = 3'b100,
        CMD_PRE = 3'b010
    } cmd_e;

    typedef struct packed {
        cmd_e            op;
        logic [BA_W-1:0] ba;
        logic            a10;
    } cmd_t;
endpackage

// File: rtl/psched_limit_calc.sv
// Turns one access into the number of edges its bank must wait before a
// precharge may be accepted (value loaded is limit minus one).
module psched_limit_calc #(
    parameter int unsigned MAX_BL = 8,
    parameter int unsigned TWR    = 2,
    parameter int unsigned BL_W   = $clog2(MAX_BL + 1),
    parameter int unsigned CNT_W  = $clog2(MAX_BL + TWR + 1)
) (
    input  logic [1:0]       cas_lat,
    input  logic             is_write,
    input  logic [BL_W-1:0]  burst,
    output logic [CNT_W-1:0] wait_cnt
);
    int cl;
    int bl;
    int last_beat;
    int earliest;

    always_comb begin
        cl        = (cas_lat == 2'd2) ? 2 : 3;
        bl        = (burst == '0) ? 1 : int'(burst);
        if (is_write) begin
            // data enters with the command; recovery counts from last beat
            last_beat = bl - 1;
            earliest  = last_beat + int'(TWR);
        end else begin
            // data leaves CL cycles after the command; close CL-1 early
            last_beat = cl + bl - 1;
            earliest  = last_beat - (cl - 1);
        end
        wait_cnt = CNT_W'(earliest - 1);
    end
endmodule

// File: rtl/psched_bank_track.sv
// One bank: open bit, pending auto-close and precharge countdown.
module psched_bank_track #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             acc_i,
    input  logic             acc_auto_i,
    input  logic [CNT_W-1:0] acc_wait_i,
    input  logic             pre_i,
    output logic             open_o,
    output logic             legal_o,
    output logic             busy_o
);
    typedef struct packed {
        logic             open;
        logic             apend;
        logic [CNT_W-1:0] cnt;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     fire;

    always_comb begin
        st_d = st_q;
        fire = st_q.apend && (st_q.cnt == '0);

        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        if (acc_i && (acc_wait_i > st_d.cnt)) begin
            st_d.cnt = acc_wait_i;
        end

        if (fire) begin
            st_d.apend = 1'b0;
        end
        if (acc_i && acc_auto_i) begin
            st_d.apend = 1'b1;
        end

        if (act_i) begin
            st_d.open = 1'b1;
        end
        if (pre_i || fire) begin
            st_d.open = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o  = st_q.open;
    assign legal_o = (st_q.cnt == '0);
    assign busy_o  = st_q.apend;
endmodule

// File: rtl/psched_arbiter.sv
// Chooses at most one command per cycle: precharge, then access, then activate.
module psched_arbiter #(
    parameter int unsigned NB   = 4,
    parameter int unsigned BA_W = 2
) (
    input  logic            pre_valid,
    input  logic            pre_all,
    input  logic [BA_W-1:0] pre_bank,
    input  logic            acc_valid,
    input  logic [BA_W-1:0] acc_bank,
    input  logic            act_valid,
    input  logic [BA_W-1:0] act_bank,
    input  logic [NB-1:0]   bank_open,
    input  logic [NB-1:0]   bank_legal,
    input  logic [NB-1:0]   bank_busy,
    output logic [NB-1:0]   pre_mask,
    output logic            pre_ready,
    output logic            acc_ready,
    output logic            act_ready,
    output logic            pre_fire,
    output logic            acc_fire,
    output logic            act_fire
);
    always_comb begin
        pre_mask = '0;
        for (int i = 0; i < int'(NB); i++) begin
            pre_mask[i] = pre_all || (pre_bank == BA_W'(i));
        end
        pre_ready = &(bank_legal | ~pre_mask);
        pre_fire  = pre_valid && pre_ready;

        acc_ready = !pre_fire && bank_open[acc_bank] && !bank_busy[acc_bank];
        acc_fire  = acc_valid && acc_ready;

        act_ready = !pre_fire && !acc_fire && !bank_open[act_bank];
        act_fire  = act_valid && act_ready;
    end
endmodule

// File: rtl/sdram_pre_sched.sv
module sdram_pre_sched
    import psched_pkg::*;
#(
    parameter int unsigned MAX_BL = 8,
    parameter int unsigned TWR    = 2,
    parameter int unsigned BL_W   = $clog2(MAX_BL + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      cas_lat,
    input  logic            pre_valid,
    output logic            pre_ready,
    input  logic            pre_all,
    input  logic [1:0]      pre_bank,
    input  logic            acc_valid,
    output logic            acc_ready,
    input  logic            acc_write,
    input  logic [1:0]      acc_bank,
    input  logic [BL_W-1:0] acc_burst,
    input  logic            acc_auto,
    input  logic            act_valid,
    output logic            act_ready,
    input  logic [1:0]      act_bank,
    output logic            cmd_ras_n,
    output logic            cmd_cas_n,
    output logic            cmd_we_n,
    output logic [1:0]      cmd_ba,
    output logic            cmd_a10,
    output logic [3:0]      bank_open
);
    localparam int unsigned CNT_W = $clog2(MAX_BL + TWR + 1);

    logic [NBANK-1:0] open_w, legal_w, busy_w, pre_mask;
    logic             pre_fire, acc_fire, act_fire;
    logic [CNT_W-1:0] acc_wait;
    cmd_t             cmd_d, cmd_q;

    psched_limit_calc #(
        .MAX_BL(MAX_BL), .TWR(TWR), .BL_W(BL_W), .CNT_W(CNT_W)
    ) u_limit (
        .cas_lat (cas_lat),
        .is_write(acc_write),
        .burst   (acc_burst),
        .wait_cnt(acc_wait)
    );

    psched_arbiter #(.NB(NBANK), .BA_W(BA_W)) u_arb (
        .pre_valid (pre_valid),
        .pre_all   (pre_all),
        .pre_bank  (pre_bank),
        .acc_valid (acc_valid),
        .acc_bank  (acc_bank),
        .act_valid (act_valid),
        .act_bank  (act_bank),
        .bank_open (open_w),
        .bank_legal(legal_w),
        .bank_busy (busy_w),
        .pre_mask  (pre_mask),
        .pre_ready (pre_ready),
        .acc_ready (acc_ready),
        .act_ready (act_ready),
        .pre_fire  (pre_fire),
        .acc_fire  (acc_fire),
        .act_fire  (act_fire)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        psched_bank_track #(.CNT_W(CNT_W)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (act_fire && (act_bank == BA_W'(b))),
            .acc_i     (acc_fire && (acc_bank == BA_W'(b))),
            .acc_auto_i(acc_auto),
            .acc_wait_i(acc_wait),
            .pre_i     (pre_fire && pre_mask[b]),
            .open_o    (open_w[b]),
            .legal_o   (legal_w[b]),
            .busy_o    (busy_w[b])
        );
    end

    always_comb begin
        cmd_d.op  = CMD_NOP;
        cmd_d.ba  = '0;
        cmd_d.a10 = 1'b0;
        if (pre_fire) begin
            cmd_d.op  = CMD_PRE;
            cmd_d.ba  = pre_all ? '0 : pre_bank;
            cmd_d.a10 = pre_all;
        end else if (acc_fire) begin
            cmd_d.op  = acc_write ? CMD_WR : CMD_RD;
            cmd_d.ba  = acc_bank;
            cmd_d.a10 = acc_auto;
        end else if (act_fire) begin
            cmd_d.op  = CMD_ACT;
            cmd_d.ba  = act_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '{op: CMD_NOP, ba: '0, a10: 1'b0};
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign {cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q.op;
    assign cmd_ba    = cmd_q.ba;
    assign cmd_a10   = cmd_q.a10;
    assign bank_open = open_w;
endmodule

// File: rtl/psched_checker.sv
module psched_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pre_valid,
    input logic       pre_ready,
    input logic       pre_all,
    input logic [1:0] pre_bank,
    input logic       acc_valid,
    input logic       acc_ready,
    input logic [1:0] acc_bank,
    input logic       acc_auto,
    input logic       act_valid,
    input logic       act_ready,
    input logic [1:0] act_bank,
    input logic       cmd_ras_n,
    input logic       cmd_cas_n,
    input logic       cmd_we_n,
    input logic [1:0] cmd_ba,
    input logic       cmd_a10,
    input logic [3:0] bank_open
);
    logic pre_go, acc_go, act_go;
    assign pre_go = pre_valid && pre_ready;
    assign acc_go = acc_valid && acc_ready;
    assign act_go = act_valid && act_ready;

    p_pre_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |=> ({cmd_ras_n, cmd_cas_n, cmd_we_n} == 3'b010));

    p_pre_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pre_go |=> (cmd_a10 == $past(pre_all)) &&
                   ($past(pre_all) ? (cmd_ba == 2'd0) : (cmd_ba == $past(pre_bank))));

    p_acc_a10_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |=> (cmd_a10 == $past(acc_auto)) && (cmd_cas_n == 1'b0));

    p_all_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_go && pre_all) |=> (bank_open == 4'b0000));

    p_pre_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_go && !pre_all) |=> !bank_open[$past(pre_bank)]);

    p_act_opens_r8: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |=> bank_open[$past(act_bank)]);

    p_one_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pre_go, acc_go, act_go}));

    p_acc_open_r10: assert property (@(posedge clk) disable iff (!rst_n)
        acc_go |-> bank_open[acc_bank]);

    p_act_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        act_go |-> !bank_open[act_bank]);
endmodule

bind sdram_pre_sched psched_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_valid(pre_valid),
    .pre_ready(pre_ready),
    .pre_all  (pre_all),
    .pre_bank (pre_bank),
    .acc_valid(acc_valid),
    .acc_ready(acc_ready),
    .acc_bank (acc_bank),
    .acc_auto (acc_auto),
    .act_valid(act_valid),
    .act_ready(act_ready),
    .act_bank (act_bank),
    .cmd_ras_n(cmd_ras_n),
    .cmd_cas_n(cmd_cas_n),
    .cmd_we_n (cmd_we_n),
    .cmd_ba   (cmd_ba),
    .cmd_a10  (cmd_a10),
    .bank_open(bank_open)
);

// File: tb/tb_sdram_pre_sched.sv
`timescale 1ns/1ps
module tb_sdram_pre_sched;
    localparam int MAX_BL = 8;
    localparam int TWR    = 2;
    localparam int BL_W   = $clog2(MAX_BL + 1);
    localparam logic [2:0] OP_NOP = 3'b111, OP_ACT = 3'b011, OP_RD = 3'b101,
                           OP_WR = 3'b100, OP_PRE = 3'b010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cas_lat = 2'd2;
    logic pre_valid = 0, pre_all = 0, acc_valid = 0, acc_write = 0, acc_auto = 0, act_valid = 0;
    logic [1:0] pre_bank = 0, acc_bank = 0, act_bank = 0;
    logic [BL_W-1:0] acc_burst = 1;
    logic pre_ready, acc_ready, act_ready, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_a10;
    logic [1:0] cmd_ba;
    logic [3:0] bank_open;

    always #5 clk = ~clk;

    sdram_pre_sched #(.MAX_BL(MAX_BL), .TWR(TWR)) dut (
        .clk(clk), .rst_n(rst_n), .cas_lat(cas_lat),
        .pre_valid(pre_valid), .pre_ready(pre_ready), .pre_all(pre_all), .pre_bank(pre_bank),
        .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_write(acc_write),
        .acc_bank(acc_bank), .acc_burst(acc_burst), .acc_auto(acc_auto),
        .act_valid(act_valid), .act_ready(act_ready), .act_bank(act_bank),
        .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n), .cmd_we_n(cmd_we_n),
        .cmd_ba(cmd_ba), .cmd_a10(cmd_a10), .bank_open(bank_open)
    );

    typedef struct { logic [2:0] op; int ba; logic a10; int bl; } item_t;
    item_t exp_q[$];

    int nchk = 0, nfail = 0, cyc = 0;
    int lim_edge[4], close_at[4];
    logic [3:0] mopen = 4'b0;
    bit pre_pend = 0;
    int pre_req = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // drivers: start just after a rising edge, push the expected command on accept
    task automatic do_act(input int b);
        bit done = 0;
        act_bank = 2'(b); act_valid = 1;
        while (!done) begin @(negedge clk); done = act_ready; end
        exp_q.push_back('{OP_ACT, b, 1'b0, 0});
        @(posedge clk); #2 act_valid = 0;
    endtask

    task automatic do_acc(input bit wr, input int b, input int bl, input bit au);
        bit done = 0;
        acc_write = wr; acc_bank = 2'(b); acc_burst = BL_W'(bl); acc_auto = au; acc_valid = 1;
        while (!done) begin @(negedge clk); done = acc_ready; end
        exp_q.push_back('{wr ? OP_WR : OP_RD, b, au, bl});
        @(posedge clk); #2 acc_valid = 0;
    endtask

    task automatic do_pre(input bit all, input int b);
        bit done = 0;
        pre_all = all; pre_bank = 2'(b); pre_valid = 1;
        while (!done) begin @(negedge clk); done = pre_ready; end
        exp_q.push_back('{OP_PRE, all ? 0 : b, all, 0});
        @(posedge clk); #2 pre_valid = 0;
    endtask

    // monitor: pops expected commands and keeps the timing and open-bank model
    initial begin
        for (int b = 0; b < 4; b++) begin lim_edge[b] = 0; close_at[b] = -1; end
        forever begin
            @(negedge clk);
            if (rst_n) begin
                logic [2:0] op;
                for (int b = 0; b < 4; b++) begin
                    if (close_at[b] >= 0 && cyc >= close_at[b]) begin
                        mopen[b] = 1'b0; close_at[b] = -1;  // R6 auto close
                    end
                end
                op = {cmd_ras_n, cmd_cas_n, cmd_we_n};
                if (op != OP_NOP) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R9 unexpected command", int'(op), int'(OP_NOP));
                    end else begin
                        item_t it;
                        int cl, l, exp_e;
                        it = exp_q.pop_front();
                        chk(op == it.op, "R1 command code", int'(op), int'(it.op));
                        chk(int'(cmd_ba) == it.ba, "R2 bank address", int'(cmd_ba), it.ba);
                        chk(cmd_a10 == it.a10, "R2 R3 A10", int'(cmd_a10), int'(it.a10));
                        cl = (cas_lat == 2'd2) ? 2 : 3;
                        if (it.op == OP_ACT) mopen[it.ba] = 1'b1;
                        if (it.op == OP_RD || it.op == OP_WR) begin
                            // R4: read closes CL-1 before last beat; R5: write waits TWR
                            l = (it.op == OP_RD) ? ((cl + it.bl - 1) - (cl - 1)) : (it.bl - 1 + TWR);
                            if (cyc + l > lim_edge[it.ba]) lim_edge[it.ba] = cyc + l;
                            if (it.a10) close_at[it.ba] = cyc + l;
                        end
                        if (it.op == OP_PRE) begin
                            exp_e = pre_req;
                            for (int b = 0; b < 4; b++)
                                if (it.a10 || b == it.ba)
                                    if (lim_edge[b] > exp_e) exp_e = lim_edge[b];
                            chk(cyc == exp_e, "R4 R5 R7 precharge cycle", cyc, exp_e);
                            for (int b = 0; b < 4; b++)
                                if (it.a10 || b == it.ba) begin mopen[b] = 1'b0; close_at[b] = -1; end
                            pre_pend = 0;
                        end
                    end
                end
                chk(bank_open == mopen, "R8 open record", int'(bank_open), int'(mopen));
                if (pre_valid && !pre_pend) begin pre_pend = 1; pre_req = cyc + 1; end
            end
        end
    end

    initial begin
        #(200000 * 10);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1;
        @(negedge clk);
        chk(bank_open == 4'b0, "R8 reset open", int'(bank_open), 0);
        chk({cmd_ras_n, cmd_cas_n, cmd_we_n} == OP_NOP, "R1 reset nop",
            int'({cmd_ras_n, cmd_cas_n, cmd_we_n}), int'(OP_NOP));
        @(posedge clk); #2;

        // R4 with CAS latency 2 and 3
        cas_lat = 2'd2;
        do_act(0); do_acc(0, 0, 4, 0); do_pre(0, 0);
        cas_lat = 2'd3;
        do_act(1); do_acc(0, 1, 8, 0); do_pre(0, 1);
        // R5 write recovery
        do_act(2); do_acc(1, 2, 4, 0); do_pre(0, 2);
        // R3 R6 auto-precharge read and write
        do_act(3); do_acc(0, 3, 2, 1);
        repeat (5) @(posedge clk); #2;
        chk(bank_open[3] == 1'b0, "R3 auto read closed", int'(bank_open[3]), 0);
        cas_lat = 2'd2;
        do_act(0); do_acc(1, 0, 4, 1);
        repeat (8) @(posedge clk); #2;
        chk(bank_open[0] == 1'b0, "R6 auto write closed", int'(bank_open[0]), 0);
        // R7 precharge all with a write and a read outstanding
        do_act(0); do_act(1);
        do_acc(1, 0, 4, 0); do_acc(0, 1, 2, 0); do_pre(1, 0);
        @(negedge clk);
        chk(bank_open == 4'b0, "R7 all closed", int'(bank_open), 0);
        @(posedge clk); #2;
        // same edge: auto close of bank 1 and explicit precharge of bank 2
        do_act(1); do_act(2);
        do_acc(1, 2, 2, 0); do_acc(0, 1, 2, 1); do_pre(0, 2);
        @(negedge clk);
        chk(bank_open[2:1] == 2'b00, "R6 simultaneous close", int'(bank_open[2:1]), 0);
        @(posedge clk); #2;
        // R10 access to a closed bank stalls
        acc_write = 0; acc_bank = 0; acc_burst = 1; acc_auto = 0; acc_valid = 1;
        repeat (3) begin @(negedge clk); chk(acc_ready == 1'b0, "R10 closed bank access", int'(acc_ready), 0); end
        @(posedge clk); #2 acc_valid = 0;
        do_act(0);
        act_bank = 0; act_valid = 1;
        @(negedge clk); chk(act_ready == 1'b0, "R10 activate open bank", int'(act_ready), 0);
        @(posedge clk); #2 act_valid = 0;
        // R10 access while auto-precharge pending
        do_acc(0, 0, 8, 1);
        acc_bank = 0; acc_auto = 0; acc_valid = 1;
        repeat (4) begin @(negedge clk); chk(acc_ready == 1'b0, "R10 pending auto", int'(acc_ready), 0); end
        @(posedge clk); #2 acc_valid = 0;
        repeat (8) @(posedge clk); #2;
        // R9 precharge and access in the same cycle
        do_act(3);
        fork
            do_pre(0, 2);
            do_acc(0, 3, 1, 0);
            begin
                @(negedge clk);
                chk(pre_ready && !acc_ready, "R9 precharge first",
                    int'({pre_ready, acc_ready}), 2);
            end
        join
        repeat (6) @(posedge clk); #2;
        chk(exp_q.size() == 0, "R1 all commands seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule